// File: doc/BRIEF.md
# Averaging ADC Conversion Sequencer

This block drives one shared analog-to-digital converter through a small programmable list of channels. Each list entry names a channel and an averaging code. For every entry the sequencer asks the converter for a group of samples, adds them up, and reports the mean together with the channel number on a one-cycle result strobe. Between primary entries it inserts a group for any sample-and-hold channel that has been triggered. The final slot of every pass is a single sample of the internal temperature channel. The pass then starts again from entry 0 for as long as the run input stays high.

A data-available flag marks the end of each pass. In a second interrupt mode the flag also sets after every (num_smp + 1) completed conversions. The flag holds until software clears it, and the interrupt output is that flag gated by an enable. The converter is outside the block. Its interface is a one-cycle start pulse carrying a channel number, and a done pulse carrying the sample.

Top module: `adc_avg_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, conv_start, res_valid, flag and irq are 0.
- R2: An averaging code of 0, 1, 2, 3 or 4 takes 1, 2, 4, 8 or 16 samples. Codes 5 to 7 take 16 samples. The reported res_data is the sum of the group's samples shifted right by the effective code. res_chan is the channel those samples were taken from.
- R3: Primary entries run in order from 0 to last_idx, and entry N_ENT-1 is always treated as the end of the list. The temperature channel (TEMP_CH, default 24) takes exactly one sample. The pass then restarts at entry 0.
- R4: After each primary group, one ready sample-and-hold group is inserted. Channel 0 (SH0_CH, default 16, code sh0_avg) is chosen before channel 1 (SH1_CH, default 17, code sh1_avg). If neither is ready, the next primary entry follows directly.
- R5: The temperature sample is always the final slot of a pass. It comes after the last entry and after any sample-and-hold group inserted behind that entry.
- R6: A one-cycle pulse on bit k of sh_trig_int or of sh_trig_pin makes sample-and-hold channel k ready. A trigger may arrive while the block is idle. The ready state is consumed when that channel's slot is chosen.
- R7: flag sets in the same cycle that res_valid reports the temperature result.
- R8: With irq_mode = 1, flag also sets after every (num_smp + 1)-th conversion, counting from the start of a run.
- R9: flag stays set until flag_clr is high for a cycle. A set event in that same cycle wins over the clear.
- R10: irq equals flag AND irq_en.
- R11: conv_start is a one-cycle pulse per sample, and no new pulse comes until conv_done. res_valid is registered in the cycle after the group's last conv_done.
- R12: When run falls, the group in progress completes, then no further conversion starts. A later run restarts at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Keep sequencing while high |
| cfg_we | input | 1 | Write strobe for the list table |
| cfg_addr | input | IDX_W | Table entry to write |
| cfg_chan | input | 5 | Channel number for the entry |
| cfg_avg | input | 3 | Averaging code for the entry |
| last_idx | input | IDX_W | Index of the final primary entry |
| sh0_avg | input | 3 | Averaging code of sample-and-hold channel 0 |
| sh1_avg | input | 3 | Averaging code of sample-and-hold channel 1 |
| sh_trig_int | input | 2 | Internal trigger pulses, one bit per sample-and-hold channel |
| sh_trig_pin | input | 2 | External enable trigger pulses, one bit per channel |
| conv_start | output | 1 | Start one conversion |
| conv_chan | output | 5 | Channel to convert |
| conv_done | input | 1 | Conversion finished |
| conv_data | input | DATA_W | Converted sample |
| res_valid | output | 1 | Averaged result strobe |
| res_chan | output | 5 | Channel of the result |
| res_data | output | DATA_W | Averaged value |
| irq_mode | input | 1 | 0: pass end only; 1: also every num_smp+1 conversions |
| num_smp | input | CNT_W | Conversion interval minus one |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear of flag |
| flag | output | 1 | Data-available flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions run on every cycle and cover the protocol and flag rules. They check that each start is a single-cycle pulse and that a result appears only right after a done. They also check that flag rises only after a conversion completes, that it holds until cleared, and that it is set whenever the temperature result is reported. The bench scenarios are needed for the rest. These are the slot order with sample-and-hold groups slotted in and the temperature slot placed at the end of the pass. They also cover the sample count and the shifted mean for every averaging code, the conversion-interval interrupt, and the clean stop and restart at entry 0.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int CH_W    = 5;
    localparam int AVG_W   = 3;
    localparam int MAX_LOG = 4;

    typedef enum logic [1:0] {SLOT_PRIM, SLOT_SH0, SLOT_SH1, SLOT_TEMP} slot_e;
    typedef enum logic [1:0] {ST_IDLE, ST_START, ST_WAIT} state_e;

    typedef struct packed {
        logic [CH_W-1:0]  chan;
        logic [AVG_W-1:0] avg;
    } entry_t;

    function automatic logic [2:0] avg_log(input logic [AVG_W-1:0] code);
        return (int'(code) > MAX_LOG) ? 3'(MAX_LOG) : 3'(code);
    endfunction
endpackage

// File: rtl/adc_seq_table.sv
module adc_seq_table
    import adc_seq_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  entry_t           wdata,
    input  logic [IDX_W-1:0] raddr,
    output entry_t           rdata
);
    entry_t ent [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ent[g] <= '0;
            else if (we && waddr == IDX_W'(g))
                ent[g] <= wdata;
        end
    end

    assign rdata = ent[raddr];
endmodule

// File: rtl/adc_seq_accum.sv
module adc_seq_accum
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 12,
    localparam int SUM_W = DATA_W + MAX_LOG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              done,
    input  logic [DATA_W-1:0] data,
    input  logic [2:0]        lg,
    output logic              group_end,
    output logic [DATA_W-1:0] avg
);
    logic [SUM_W-1:0] sum, sum_nx, shifted;
    logic [MAX_LOG:0] cnt, last_cnt;

    assign sum_nx    = sum + SUM_W'(data);
    assign last_cnt  = (MAX_LOG+1)'((1 << lg) - 1);
    assign group_end = done && (cnt == last_cnt);
    assign shifted   = sum_nx >> lg;
    assign avg       = shifted[DATA_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum <= '0;
            cnt <= '0;
        end else if (done) begin
            if (group_end) begin
                sum <= '0;
                cnt <= '0;
            end else begin
                sum <= sum_nx;
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_seq_irq.sv
module adc_seq_irq #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             done,
    input  logic             pass_end,
    input  logic             mode,
    input  logic [CNT_W-1:0] num_smp,
    input  logic             en,
    input  logic             clr,
    output logic             flag,
    output logic             irq
);
    logic [CNT_W-1:0] cnt;
    logic             hit, set_ev;

    assign hit    = done && (cnt == num_smp);
    assign set_ev = pass_end || (mode && hit);
    assign irq    = flag & en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else begin
            if (restart)
                cnt <= '0;
            else if (done)
                cnt <= hit ? '0 : cnt + 1'b1;
            if (set_ev)
                flag <= 1'b1;
            else if (clr)
                flag <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_avg_seq.sv
module adc_avg_seq
    import adc_seq_pkg::*;
#(
    parameter int N_ENT  = 8,
    parameter int DATA_W = 12,
    parameter int CNT_W  = 8,
    parameter logic [CH_W-1:0] SH0_CH  = 5'd16,
    parameter logic [CH_W-1:0] SH1_CH  = 5'd17,
    parameter logic [CH_W-1:0] TEMP_CH = 5'd24,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_addr,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic [AVG_W-1:0]  cfg_avg,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic [AVG_W-1:0]  sh0_avg,
    input  logic [AVG_W-1:0]  sh1_avg,
    input  logic [1:0]        sh_trig_int,
    input  logic [1:0]        sh_trig_pin,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              res_valid,
    output logic [CH_W-1:0]   res_chan,
    output logic [DATA_W-1:0] res_data,
    input  logic              irq_mode,
    input  logic [CNT_W-1:0]  num_smp,
    input  logic              irq_en,
    input  logic              flag_clr,
    output logic              flag,
    output logic              irq
);
    state_e            st;
    slot_e             kind, nkind;
    logic [IDX_W-1:0]  idx, nidx;
    logic [1:0]        rdy, take;
    entry_t            cur_ent;
    logic [CH_W-1:0]   cur_chan;
    logic [AVG_W-1:0]  cur_avg;
    logic              acc_done, grp_end, pass_end, is_last;
    logic [DATA_W-1:0] avg_val;

    adc_seq_table #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_tab (
        .clk(clk), .rst(rst), .we(cfg_we), .waddr(cfg_addr),
        .wdata('{chan: cfg_chan, avg: cfg_avg}),
        .raddr(idx), .rdata(cur_ent)
    );

    always_comb begin
        case (kind)
            SLOT_SH0:  begin cur_chan = SH0_CH;       cur_avg = sh0_avg;     end
            SLOT_SH1:  begin cur_chan = SH1_CH;       cur_avg = sh1_avg;     end
            SLOT_TEMP: begin cur_chan = TEMP_CH;      cur_avg = '0;          end
            default:   begin cur_chan = cur_ent.chan; cur_avg = cur_ent.avg; end
        endcase
    end

    assign acc_done   = conv_done && (st == ST_WAIT);
    assign pass_end   = grp_end && (kind == SLOT_TEMP);
    assign conv_start = (st == ST_START);
    assign conv_chan  = cur_chan;
    assign is_last    = (idx == last_idx) || (idx == IDX_W'(N_ENT - 1));

    adc_seq_accum #(.DATA_W(DATA_W)) u_acc (
        .clk(clk), .rst(rst), .clr(st == ST_IDLE), .done(acc_done),
        .data(conv_data), .lg(avg_log(cur_avg)),
        .group_end(grp_end), .avg(avg_val)
    );

    adc_seq_irq #(.CNT_W(CNT_W)) u_irq (
        .clk(clk), .rst(rst), .restart(st == ST_IDLE), .done(acc_done),
        .pass_end(pass_end), .mode(irq_mode), .num_smp(num_smp),
        .en(irq_en), .clr(flag_clr), .flag(flag), .irq(irq)
    );

    // slot chooser: primary, then at most one ready sample-and-hold, temperature last
    always_comb begin
        nkind = SLOT_PRIM;
        nidx  = idx;
        take  = 2'b00;
        case (kind)
            SLOT_PRIM: begin
                if (rdy[0]) begin
                    nkind = SLOT_SH0;
                    take  = 2'b01;
                end else if (rdy[1]) begin
                    nkind = SLOT_SH1;
                    take  = 2'b10;
                end else if (is_last) begin
                    nkind = SLOT_TEMP;
                end else begin
                    nidx = idx + 1'b1;
                end
            end
            SLOT_TEMP: nidx = '0;
            default: begin
                if (is_last) nkind = SLOT_TEMP;
                else         nidx  = idx + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            kind      <= SLOT_PRIM;
            idx       <= '0;
            rdy       <= '0;
            res_valid <= 1'b0;
            res_chan  <= '0;
            res_data  <= '0;
        end else begin
            rdy       <= (rdy & ~(take & {2{grp_end}})) | sh_trig_int | sh_trig_pin;
            res_valid <= grp_end;
            if (grp_end) begin
                res_chan <= cur_chan;
                res_data <= avg_val;
            end
            case (st)
                ST_IDLE: if (run) begin
                    st   <= ST_START;
                    kind <= SLOT_PRIM;
                    idx  <= '0;
                end
                ST_START: st <= ST_WAIT;
                default: if (conv_done) begin
                    if (grp_end) begin
                        kind <= nkind;
                        idx  <= nidx;
                        st   <= run ? ST_START : ST_IDLE;
                    end else begin
                        st <= ST_START;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
#(
    parameter logic [CH_W-1:0] TEMP_CH = 5'd24
) (
    input logic            clk,
    input logic            rst,
    input logic            conv_start,
    input logic            conv_done,
    input logic            res_valid,
    input logic [CH_W-1:0] res_chan,
    input logic            flag,
    input logic            flag_clr
);
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start); // R11
    AST_RES_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(conv_done)); // R11
    AST_TEMP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_chan == TEMP_CH) |-> flag); // R7
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag); // R9
    AST_FLAG_RISE_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(conv_done)); // R8
endmodule

bind adc_avg_seq adc_seq_chk #(.TEMP_CH(TEMP_CH)) u_chk (
    .clk(clk), .rst(rst), .conv_start(conv_start), .conv_done(conv_done),
    .res_valid(res_valid), .res_chan(res_chan), .flag(flag), .flag_clr(flag_clr)
);

// File: tb/sim_adc_avg_seq.sv
module sim_adc_avg_seq;
    localparam int LAT = 3;
    localparam int TCH = 24, S0 = 16, S1 = 17;

    logic clk = 0, rst = 1, run = 0, cfg_we = 0;
    logic [2:0] cfg_addr = 0, last_idx = 0;
    logic [4:0] cfg_chan = 0;
    logic [2:0] cfg_avg = 0, sh0_avg = 0, sh1_avg = 0;
    logic [1:0] sh_trig_int = 0, sh_trig_pin = 0;
    logic conv_start, conv_done = 0, res_valid, flag, irq;
    logic [4:0] conv_chan, res_chan;
    logic [11:0] conv_data = 0, res_data;
    logic irq_mode = 0, irq_en = 0, flag_clr = 0;
    logic [7:0] num_smp = 0;

    adc_avg_seq u0 (.*);

    always #10 clk = ~clk;

    int errs = 0, checks = 0, cyc = 0, last_start = 0;
    int exp_ch [64];
    int exp_lg [64];
    int nexp = 0, rcount = 0, acc = 0, nacc = 0, gk = 0, cnum = 0, last_ch = 0;
    bit seen_temp = 0, mode1 = 0, finished = 0;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic ex(input int ch, input int lg);
        exp_ch[nexp] = ch;
        exp_lg[nexp] = lg;
        nexp++;
    endtask

    task automatic wr(input int a, input int ch, input int code);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 3'(a); cfg_chan = 5'(ch); cfg_avg = 3'(code);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
        chk(flag == 0, "R9 clear", int'(flag), 0);
        seen_temp = 0;
    endtask

    task automatic run_for(input int n);
        rcount = 0; acc = 0; nacc = 0; cnum = 0;
        @(negedge clk); run = 1;
        while (rcount < n) @(negedge clk);
        run = 0;
        repeat (300) @(negedge clk);
        chk(rcount == n + 1, "R12 groups after stop", rcount, n + 1);
        chk(cyc - last_start > 200, "R12 no start after stop", cyc - last_start, 201);
        nexp = 0;
    endtask

    // converter model and result monitor
    initial begin
        forever begin
            @(negedge clk);
            if (conv_done) begin
                conv_done = 0;
                cnum++;
                if (mode1)
                    chk(flag == ((cnum % 3) == 0 || last_ch == TCH), "R8 R9 interval flag",
                        int'(flag), int'((cnum % 3) == 0 || last_ch == TCH));
            end
            if (res_valid) begin
                if (rcount < nexp) begin
                    chk(res_chan == 5'(exp_ch[rcount]), "R3 R4 R5 result channel",
                        int'(res_chan), exp_ch[rcount]);
                    chk(nacc == (1 << exp_lg[rcount]), "R2 sample count", nacc, 1 << exp_lg[rcount]);
                    chk(res_data == 12'(acc >> exp_lg[rcount]), "R2 average",
                        int'(res_data), acc >> exp_lg[rcount]);
                    if (!mode1) begin
                        if (exp_ch[rcount] == TCH) seen_temp = 1;
                        chk(flag == seen_temp, "R7 R9 flag", int'(flag), int'(seen_temp));
                        chk(irq == (seen_temp & irq_en), "R10 irq", int'(irq), int'(seen_temp & irq_en));
                    end
                end
                rcount++; acc = 0; nacc = 0;
            end
            if (conv_start) begin
                last_ch = int'(conv_chan);
                last_start = cyc;
                if (rcount < nexp)
                    chk(conv_chan == 5'(exp_ch[rcount]), "R4 R6 sampled channel",
                        int'(conv_chan), exp_ch[rcount]);
                repeat (LAT - 1) begin
                    @(negedge clk);
                    chk(!conv_start, "R11 start pulse", int'(conv_start), 0);
                end
                conv_data = 12'((gk * 97 + last_ch * 13 + 5) % 4096);
                conv_done = 1;
                acc += int'(conv_data);
                nacc++;
                gk++;
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(conv_start == 0 && res_valid == 0, "R1 reset outputs", int'(conv_start) + int'(res_valid), 0);
        chk(flag == 0 && irq == 0, "R1 reset flag", int'(flag) + int'(irq), 0);
        rst = 0;
        @(negedge clk);
        chk(conv_start == 0 && flag == 0, "R1 after reset", int'(conv_start) + int'(flag), 0);

        // A: three entries, two passes, interrupt disabled
        wr(0, 2, 0); wr(1, 5, 2); wr(2, 9, 4);
        last_idx = 2; irq_en = 0;
        for (int p = 0; p < 3; p++) begin ex(2, 0); ex(5, 2); ex(9, 4); ex(TCH, 0); end
        run_for(8);
        clear_flag();

        // sweep of every averaging code over a full list
        for (int i = 0; i < 8; i++) wr(i, i + 1, i);
        last_idx = 7; irq_en = 1;
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 8; i++) ex(i + 1, (i > 4) ? 4 : i);
            ex(TCH, 0);
        end
        run_for(9);
        clear_flag();

        // B: both sample-and-hold channels triggered while idle
        wr(0, 2, 0); wr(1, 5, 2); wr(2, 9, 4);
        last_idx = 2; sh0_avg = 1; sh1_avg = 2;
        @(negedge clk); sh_trig_int = 2'b01; sh_trig_pin = 2'b10;
        @(negedge clk); sh_trig_int = 0; sh_trig_pin = 0;
        ex(2, 0); ex(S0, 1); ex(5, 2); ex(S1, 2); ex(9, 4); ex(TCH, 0);
        for (int p = 0; p < 2; p++) begin ex(2, 0); ex(5, 2); ex(9, 4); ex(TCH, 0); end
        run_for(10);
        clear_flag();

        // C: single entry; temperature stays the last slot of each pass
        last_idx = 0; irq_en = 0;
        @(negedge clk); sh_trig_pin = 2'b01; sh_trig_int = 2'b10;
        @(negedge clk); sh_trig_int = 0; sh_trig_pin = 0;
        ex(2, 0); ex(S0, 1); ex(TCH, 0); ex(2, 0); ex(S1, 2); ex(TCH, 0);
        for (int p = 0; p < 3; p++) begin ex(2, 0); ex(TCH, 0); end
        run_for(9);
        clear_flag();

        // D: conversion-interval interrupt with clear held high
        wr(0, 3, 4); last_idx = 0; irq_en = 1;
        num_smp = 2; irq_mode = 1; flag_clr = 1; mode1 = 1;
        for (int p = 0; p < 4; p++) begin ex(3, 4); ex(TCH, 0); end
        run_for(6);
        mode1 = 0; irq_mode = 0; flag_clr = 0;
        clear_flag();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule